// File: doc/BRIEF.md
# Flow-Table Mesh Router Switching Core

This block is the switching core of a five-port mesh router. Its ports are four neighbour links and one local port toward the attached processing element. It does not compute a route from addresses. The output port of every packet comes from a flow table that a central controller fills at run time. Each input port owns a small flit buffer. The packet's header flit is looked up in the first pipeline stage. The flit crosses the crossbar into a registered output in the second stage.

When a header finds no valid flow entry, the block issues a route request that carries the packet ID and the input port code. The packet then waits in its buffer until the controller writes the entry, either as a first install or as an update. An output stays bound to one input from the header to the tail of that packet. Contention for a free output is settled by packet priority first and by a round-robin pointer second. Flits are never dropped. Backpressure reaches the sender through the per-input ready signal.

Top module: `flow_switch`

## Requirements
- R1: While reset is held and on the first cycle after it, every out_valid bit and req_valid are 0. Every in_ready bit is 1 once reset is released.
- R2: A flit is 16 bits wide. Bits [15:14] hold the kind: 01 header, 00 body, 10 tail, 11 single-flit packet. Bit 13 is the priority (1 high, 0 low), bits [12:9] the packet ID and bits [8:0] the payload. A header whose ID has a valid entry leaves on the output whose code the entry holds (0 north, 1 east, 2 south, 3 west, 4 local). It is unchanged, and out_valid rises two clock edges after the edge that accepted it.
- R3: A header with no valid entry causes exactly one single-cycle req_valid pulse, with req_id set to its packet ID and req_port set to its input code. The header is not forwarded while the entry is invalid.
- R4: A cfg_valid write with a port code of 0 to 4 makes the entry for cfg_id valid with that port. A header waiting on that ID is then forwarded to that port.
- R5: Body and tail flits follow their header's output in order, whatever their ID bits hold.
- R6: Once an output accepts a header, it carries only that input's flits until the tail has passed. A competing packet waits.
- R7: When headers of both priorities compete for a free output in the same cycle, a high-priority header is granted before a low-priority one.
- R8: Among competing headers of equal priority, grants rotate round-robin. An input that has just been served yields to the other waiting inputs.
- R9: No flit is lost or altered. An output held with out_ready low keeps its flit stable. An input whose 4-flit buffer is full drives in_ready low.
- R10: A cfg_valid write with a port code of 5, 6 or 7 leaves the table unchanged.
- R11: A write to an ID that already holds a valid entry replaces its port, and later packets with that ID use the new port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per-input flit valid |
| in_ready | output | 5 | Per-input buffer has room |
| in_data | input | 80 | Five 16-bit input flits, port p at bits [16p+15:16p] |
| out_valid | output | 5 | Per-output flit valid |
| out_ready | input | 5 | Per-output downstream accepts |
| out_data | output | 80 | Five 16-bit output flits, port p at bits [16p+15:16p] |
| req_valid | output | 1 | Route request pulse toward the controller |
| req_id | output | 4 | Packet ID of the route request |
| req_port | output | 3 | Input port code that missed |
| cfg_valid | input | 1 | Flow entry write strobe (route reply or flow update) |
| cfg_id | input | 4 | Packet ID of the entry written |
| cfg_port | input | 3 | Output port code written |

## Verification
The bench targets a body flit whose ID bits point elsewhere. A design that looks up every flit would scatter that packet across outputs. It also targets a single-flit packet that arrives behind a locked output. A design that released the lock early would interleave it into the middle of another packet. Same-cycle contention is arranged so that a fixed-priority arbiter would serve the same input twice in a row, and so that the round-robin favourite holds the low-priority header. Either arbitration mistake then changes the output order. A miss followed by a write with a bad port code must still leave the packet parked with no second request, and a full buffer held under backpressure must deliver all six flits in order once released.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int NPORT  = 5;
  localparam int PORT_W = 3;

  typedef enum logic [1:0] {
    K_BODY = 2'b00,
    K_HEAD = 2'b01,
    K_TAIL = 2'b10,
    K_SOLO = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MISS,
    S_WAIT,
    S_READY,
    S_BUSY
  } in_state_e;
endpackage

// File: rtl/fsw_fifo.sv
module fsw_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/fsw_flow_table.sv
module fsw_flow_table #(
  parameter int ID_W   = 4,
  parameter int PORT_W = 3,
  parameter int NPORT  = 5,
  parameter int NRD    = 5,
  parameter int NENT   = 2 ** ID_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ID_W-1:0]             wr_id,
  input  logic [PORT_W-1:0]           wr_port,
  input  logic [NRD-1:0][ID_W-1:0]    rd_id,
  output logic [NRD-1:0]              rd_hit,
  output logic [NRD-1:0][PORT_W-1:0] rd_port,
  output logic [NENT-1:0]             vld_o
);
  logic [PORT_W-1:0] port_mem [NENT];
  logic [NENT-1:0]   vld;
  logic              wr_ok;

  assign wr_ok = wr_en && (wr_port < PORT_W'(NPORT));
  assign vld_o = vld;

  always_ff @(posedge clk) begin
    if (wr_ok) port_mem[wr_id] <= wr_port;
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_ok) vld[wr_id] <= 1'b1;
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rd_hit[r]  = vld[rd_id[r]];
      rd_port[r] = port_mem[rd_id[r]];
    end
  end
endmodule

// File: rtl/fsw_out_port.sv
module fsw_out_port #(
  parameter int NPORT = 5,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORT-1:0]         cand,
  input  logic [NPORT-1:0]         cand_hi,
  input  logic [NPORT-1:0]         avail,
  input  logic [NPORT-1:0][W-1:0]  heads,
  input  logic                     out_ready,
  output logic [NPORT-1:0]         take,
  output logic                     out_valid,
  output logic [W-1:0]             out_data
);
  localparam int IW = $clog2(NPORT);

  logic             locked;
  logic [IW-1:0]    owner, rr_ptr, pick, sel;
  logic             pick_ok, can_load, move;
  logic [NPORT-1:0] elig;
  int               idx;

  always_comb begin
    elig    = (|(cand & cand_hi)) ? (cand & cand_hi) : cand;
    pick    = '0;
    pick_ok = 1'b0;
    idx     = 0;
    for (int s = 1; s <= NPORT; s++) begin
      idx = (int'(rr_ptr) + s) % NPORT;
      if (!pick_ok && elig[idx]) begin
        pick    = IW'(idx);
        pick_ok = 1'b1;
      end
    end
  end

  always_comb begin
    can_load = !out_valid || out_ready;
    sel      = locked ? owner : pick;
    move     = can_load && (locked ? avail[owner] : pick_ok);
    take     = '0;
    if (move) take[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      locked    <= 1'b0;
      owner     <= '0;
      rr_ptr    <= IW'(NPORT - 1);
    end else begin
      if (move) begin
        out_valid <= 1'b1;
        out_data  <= heads[sel];
        locked    <= !heads[sel][W-1];
        owner     <= sel;
        if (!locked) rr_ptr <= sel;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flow_switch.sv
module flow_switch
  import fsw_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORT-1:0]          in_valid,
  output logic [NPORT-1:0]          in_ready,
  input  logic [NPORT*FLIT_W-1:0]   in_data,
  output logic [NPORT-1:0]          out_valid,
  input  logic [NPORT-1:0]          out_ready,
  output logic [NPORT*FLIT_W-1:0]   out_data,
  output logic                      req_valid,
  output logic [ID_W-1:0]           req_id,
  output logic [PORT_W-1:0]         req_port,
  input  logic                      cfg_valid,
  input  logic [ID_W-1:0]           cfg_id,
  input  logic [PORT_W-1:0]         cfg_port
);
  localparam int NENT     = 2 ** ID_W;
  localparam int PRIO_BIT = FLIT_W - 3;
  localparam int ID_LSB   = FLIT_W - 3 - ID_W;
  localparam int TAIL_BIT = FLIT_W - 1;

  logic [NPORT-1:0][FLIT_W-1:0] head;
  logic [NPORT-1:0][ID_W-1:0]   head_id;
  logic [NPORT-1:0]             empty, full, pop;
  logic [NPORT-1:0]             hit;
  logic [NPORT-1:0][PORT_W-1:0] hit_port;
  logic [NPORT-1:0]             is_ready, is_miss, hi_prio;
  logic [NPORT-1:0][PORT_W-1:0] route;
  logic [NPORT-1:0][NPORT-1:0]  take;
  logic [NPORT-1:0]             req_gnt;
  logic                         found;
  logic [NENT-1:0]              tbl_vld;

  // Stage one: per-input buffer and lookup state
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    in_state_e         st;
    logic [PORT_W-1:0] rport;

    fsw_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .rst   (rst),
      .push  (in_valid[i]),
      .din   (in_data[i*FLIT_W +: FLIT_W]),
      .pop   (pop[i]),
      .dout  (head[i]),
      .empty (empty[i]),
      .full  (full[i])
    );

    assign in_ready[i] = !full[i];
    assign head_id[i]  = head[i][ID_LSB +: ID_W];
    assign hi_prio[i]  = head[i][PRIO_BIT];
    assign is_ready[i] = (st == S_READY);
    assign is_miss[i]  = (st == S_MISS) && !hit[i];
    assign route[i]    = rport;

    always_ff @(posedge clk) begin
      if (rst) begin
        st    <= S_IDLE;
        rport <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            if (!empty[i]) begin
              if (hit[i]) begin
                st    <= S_READY;
                rport <= hit_port[i];
              end else begin
                st <= S_MISS;
              end
            end
          end
          S_MISS, S_WAIT: begin
            if (hit[i]) begin
              st    <= S_READY;
              rport <= hit_port[i];
            end else if (req_gnt[i]) begin
              st <= S_WAIT;
            end
          end
          S_READY, S_BUSY: begin
            if (pop[i]) st <= head[i][TAIL_BIT] ? S_IDLE : S_BUSY;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  fsw_flow_table #(
    .ID_W(ID_W), .PORT_W(PORT_W), .NPORT(NPORT), .NRD(NPORT), .NENT(NENT)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_valid),
    .wr_id   (cfg_id),
    .wr_port (cfg_port),
    .rd_id   (head_id),
    .rd_hit  (hit),
    .rd_port (hit_port),
    .vld_o   (tbl_vld)
  );

  // Route request: lowest-numbered missing input goes first
  always_comb begin
    req_gnt = '0;
    found   = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (is_miss[i] && !found) begin
        req_gnt[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_id    <= '0;
      req_port  <= '0;
    end else begin
      req_valid <= found;
      for (int i = 0; i < NPORT; i++) begin
        if (req_gnt[i]) begin
          req_id   <= head_id[i];
          req_port <= PORT_W'(i);
        end
      end
    end
  end

  // Stage two: allocation and crossbar traversal per output
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [NPORT-1:0] cand;

    always_comb begin
      for (int i = 0; i < NPORT; i++)
        cand[i] = is_ready[i] && (route[i] == PORT_W'(o));
    end

    fsw_out_port #(.NPORT(NPORT), .W(FLIT_W)) u_out (
      .clk       (clk),
      .rst       (rst),
      .cand      (cand),
      .cand_hi   (hi_prio),
      .avail     (~empty),
      .heads     (head),
      .out_ready (out_ready[o]),
      .take      (take[o]),
      .out_valid (out_valid[o]),
      .out_data  (out_data[o*FLIT_W +: FLIT_W])
    );
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++) pop = pop | take[o];
  end
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker #(
  parameter int NPORT  = 5,
  parameter int FLIT_W = 16,
  parameter int ID_W   = 4,
  parameter int PORT_W = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NPORT-1:0]          out_valid,
  input logic [NPORT-1:0]          out_ready,
  input logic [NPORT*FLIT_W-1:0]   out_data,
  input logic                      req_valid,
  input logic                      cfg_valid,
  input logic [ID_W-1:0]           cfg_id,
  input logic [PORT_W-1:0]         cfg_port,
  input logic [(2**ID_W)-1:0]      tbl_vld,
  input logic [NPORT-1:0][NPORT-1:0] take
);
  // R1: reset clears outputs and request
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (out_valid == '0) && !req_valid);

  // R4: legal write installs the entry
  assert_cfg_install_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && (cfg_port < PORT_W'(NPORT)) |=> tbl_vld[$past(cfg_id)]);

  // R10: illegal port code leaves the table alone
  assert_bad_port_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && (cfg_port >= PORT_W'(NPORT)) |=> $stable(tbl_vld));

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    // R9: a stalled output keeps its flit
    assert_no_drop_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] && !out_ready[o] |=>
        out_valid[o] && $stable(out_data[o*FLIT_W +: FLIT_W]));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    logic [NPORT-1:0] col;
    always_comb begin
      for (int o = 0; o < NPORT; o++) col[o] = take[o][i];
    end
    // R6: an input feeds at most one output per cycle
    assert_single_owner_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col));
  end
endmodule

bind flow_switch fsw_checker #(
  .NPORT(fsw_pkg::NPORT), .FLIT_W(FLIT_W), .ID_W(ID_W), .PORT_W(fsw_pkg::PORT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .req_valid (req_valid),
  .cfg_valid (cfg_valid),
  .cfg_id    (cfg_id),
  .cfg_port  (cfg_port),
  .tbl_vld   (tbl_vld),
  .take      (take)
);

// File: tb/flow_switch_bench.sv
module flow_switch_bench;
  import fsw_pkg::*;
  localparam int W = 16;
  localparam int IDW = 4;

  // {src, id, prio, dst}, one nibble each
  localparam logic [15:0] VEC [6] = '{16'h0102, 16'h1213, 16'h2304,
                                      16'h3400, 16'h4511, 16'h2602};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NPORT-1:0]   in_valid = '0;
  logic [NPORT-1:0]   in_ready;
  logic [NPORT*W-1:0] in_data = '0;
  logic [NPORT-1:0]   out_valid;
  logic [NPORT-1:0]   out_ready = '1;
  logic [NPORT*W-1:0] out_data;
  logic               req_valid;
  logic [IDW-1:0]     req_id;
  logic [PORT_W-1:0]  req_port;
  logic               cfg_valid = 1'b0;
  logic [IDW-1:0]     cfg_id = '0;
  logic [PORT_W-1:0]  cfg_port = '0;

  flow_switch u_flow_switch (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .req_valid(req_valid), .req_id(req_id), .req_port(req_port),
    .cfg_valid(cfg_valid), .cfg_id(cfg_id), .cfg_port(cfg_port)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] rec [NPORT][64];
  int rcnt [NPORT] = '{default: 0};
  int req_cnt = 0;
  logic [IDW-1:0] last_req_id = '0;
  logic [PORT_W-1:0] last_req_port = '0;

  // Observe transfers just before each rising edge
  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      for (int o = 0; o < NPORT; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          if (rcnt[o] < 64) rec[o][rcnt[o]] = out_data[o*W +: W];
          rcnt[o]++;
        end
      end
      if (req_valid) begin
        req_cnt++;
        last_req_id   = req_id;
        last_req_port = req_port;
      end
    end
  end

  function automatic logic [W-1:0] mk(input kind_e k, input logic pr,
                                      input logic [3:0] id, input logic [8:0] pay);
    return {k, pr, id, pay};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int p, input logic [W-1:0] f);
    in_valid[p] = 1'b1;
    in_data[p*W +: W] = f;
    while (!in_ready[p]) @(negedge clk);
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] id, input logic [2:0] port);
    cfg_valid = 1'b1;
    cfg_id = id;
    cfg_port = port;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  function automatic int total();
    int t = 0;
    for (int o = 0; o < NPORT; o++) t += rcnt[o];
    return t;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b, b2, rq, t0;
    logic [W-1:0] f;
    logic [W-1:0] fa, fb, fc, fd;
    repeat (4) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'h0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'h1f);
    chk("R1 req_valid after reset", 32'(req_valid), 32'h0);

    // R2: vector table of installed routes and single-flit packets
    for (int k = 0; k < 6; k++) begin
      int src, dst;
      src = int'(VEC[k][15:12]);
      dst = int'(VEC[k][3:0]);
      cfg(VEC[k][11:8], VEC[k][2:0]);
      b = rcnt[dst];
      f = mk(K_SOLO, VEC[k][4], VEC[k][11:8], 9'(k + 64));
      push(src, f);
      idle(6);
      chk("R2 vector arrival count", 32'(rcnt[dst]), 32'(b + 1));
      chk("R2 vector flit", 32'(rec[dst][b]), 32'(f));
    end

    // R2: exact latency of a hit
    cfg(4'd7, 3'd1);
    push(0, mk(K_SOLO, 1'b0, 4'd7, 9'h033));
    @(negedge clk); #1;
    chk("R2 out_valid one edge early", 32'(out_valid[1]), 32'h0);
    @(negedge clk); #1;
    chk("R2 out_valid on second edge", 32'(out_valid[1]), 32'h1);
    @(negedge clk);
    idle(3);

    // R3: miss raises one request and parks the packet
    rq = req_cnt;
    t0 = total();
    push(1, mk(K_SOLO, 1'b0, 4'd9, 9'h055));
    idle(8);
    chk("R3 single request pulse", 32'(req_cnt), 32'(rq + 1));
    chk("R3 request id", 32'(last_req_id), 32'h9);
    chk("R3 request port", 32'(last_req_port), 32'h1);
    chk("R3 nothing forwarded on miss", 32'(total()), 32'(t0));
    // R10: bad port code is ignored, packet stays parked
    cfg(4'd9, 3'd6);
    idle(6);
    chk("R10 bad write leaves entry invalid", 32'(total()), 32'(t0));
    chk("R10 no repeated request", 32'(req_cnt), 32'(rq + 1));
    // R4: legal install releases it
    b = rcnt[2];
    cfg(4'd9, 3'd2);
    idle(5);
    chk("R4 parked packet released", 32'(rcnt[2]), 32'(b + 1));
    chk("R4 released flit", 32'(rec[2][b]), 32'(mk(K_SOLO, 1'b0, 4'd9, 9'h055)));
    // R10: bad code must not overwrite a valid entry
    cfg(4'd7, 3'd7);
    b = rcnt[1];
    push(2, mk(K_SOLO, 1'b0, 4'd7, 9'h077));
    idle(6);
    chk("R10 valid entry kept", 32'(rcnt[1]), 32'(b + 1));

    // R11: flow update moves ID 2 from west to local
    cfg(4'd2, 3'd4);
    b = rcnt[4];
    b2 = rcnt[3];
    push(0, mk(K_SOLO, 1'b1, 4'd2, 9'h0a2));
    idle(6);
    chk("R11 updated port used", 32'(rcnt[4]), 32'(b + 1));
    chk("R11 old port unused", 32'(rcnt[3]), 32'(b2));

    // R5/R6: multi-flit packet with junk body ID, competitor behind the lock
    cfg(4'd10, 3'd0);
    b = rcnt[0];
    b2 = rcnt[4];
    fa = mk(K_HEAD, 1'b0, 4'd10, 9'h001);
    fb = mk(K_BODY, 1'b0, 4'd3, 9'h002);
    fc = mk(K_TAIL, 1'b0, 4'd0, 9'h003);
    fd = mk(K_SOLO, 1'b1, 4'd10, 9'h099);
    fork
      begin push(3, fa); push(3, fb); push(3, fc); end
      begin @(negedge clk); push(4, fd); end
    join
    idle(10);
    chk("R5 header first", 32'(rec[0][b]), 32'(fa));
    chk("R5 body follows header", 32'(rec[0][b+1]), 32'(fb));
    chk("R5 tail follows body", 32'(rec[0][b+2]), 32'(fc));
    chk("R5 body id not looked up", 32'(rcnt[4]), 32'(b2));
    chk("R6 competitor after tail", 32'(rec[0][b+3]), 32'(fd));

    // R7: priority beats round robin, both arrangements
    cfg(4'd11, 3'd2);
    cfg(4'd12, 3'd2);
    for (int a = 0; a < 2; a++) begin
      logic [W-1:0] hi, lo;
      b = rcnt[2];
      hi = mk(K_SOLO, 1'b1, 4'd12, 9'(16 * a + 1));
      lo = mk(K_SOLO, 1'b0, 4'd11, 9'(16 * a + 2));
      fork
        push(a, hi);
        push(1 - a, lo);
      join
      idle(6);
      chk("R7 high priority first", 32'(rec[2][b]), 32'(hi));
      chk("R7 low priority second", 32'(rec[2][b+1]), 32'(lo));
    end

    // R8: round robin among equal priority
    cfg(4'd13, 3'd3);
    b = rcnt[3];
    fork
      begin push(1, mk(K_SOLO, 1'b0, 4'd13, 9'h011));
            push(1, mk(K_SOLO, 1'b0, 4'd13, 9'h012)); end
      push(2, mk(K_SOLO, 1'b0, 4'd13, 9'h021));
      push(3, mk(K_SOLO, 1'b0, 4'd13, 9'h031));
    join
    idle(12);
    chk("R8 all four delivered", 32'(rcnt[3]), 32'(b + 4));
    begin
      logic [3:0] s0, s1, s2;
      s0 = rec[3][b][7:4];
      s1 = rec[3][b+1][7:4];
      s2 = rec[3][b+2][7:4];
      chk("R8 first three grants distinct", 32'((s0 != s1) && (s1 != s2) && (s0 != s2)), 32'h1);
    end

    // R9: backpressure fills the buffer without loss
    cfg(4'd14, 3'd0);
    b = rcnt[0];
    out_ready[0] = 1'b0;
    fork
      begin
        push(4, mk(K_HEAD, 1'b0, 4'd14, 9'h0a0));
        for (int k = 1; k < 5; k++) push(4, mk(K_BODY, 1'b0, 4'd14, 9'(160 + k)));
        push(4, mk(K_TAIL, 1'b0, 4'd14, 9'h0a5));
      end
      begin
        idle(12);
        chk("R9 in_ready low when buffer full", 32'(in_ready[4]), 32'h0);
        chk("R9 stalled output holds flit", 32'(out_valid[0]), 32'h1);
        chk("R9 nothing consumed while stalled", 32'(rcnt[0]), 32'(b));
        out_ready[0] = 1'b1;
      end
    join
    idle(12);
    chk("R9 all six flits delivered", 32'(rcnt[0]), 32'(b + 6));
    for (int k = 0; k < 6; k++)
      chk("R9 flit order", 32'(rec[0][b+k][8:0]), 32'(160 + k));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule